// File: doc/BRIEF.md
# CAN Protocol Error Status Capture

This block sits beside a CAN protocol engine and turns the engine's one-cycle error and completion pulses into a readable status word and a set of sticky interrupt flags. It keeps two 3-bit error codes. One records the most recent error seen while the engine was in the arbitration phase. The other records the most recent error seen while the engine was in the data phase. The engine's data-phase flag decides which code an error goes to.

Software works through a small register port with three registers: status, interrupt flags and interrupt enables. Reading the status register puts both codes back to a "nothing new" value, so each read shows only what happened since the previous read. While the engine is recovering from bus-off, every run of eleven recessive bits it detects appears in the arbitration code as a bit0 error. This lets software follow the recovery. A single interrupt line is asserted whenever an enabled flag is set.

Top module: `can_err_status`

## Requirements
- R1: After reset, both error code fields hold 7, the flag register and the enable register are all zero, and `irq` is low.
- R2: Error codes are 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC; 0 means a frame completed cleanly, and 7 means nothing new. Pulse bits `err_ev[0..5]` map to codes 1..6. When several error pulses arrive in one cycle, the lowest code is stored.
- R3: An error pulse with `in_data_phase` low loads the arbitration code (status bits [2:0]) and sets flag bit 27. An error pulse with `in_data_phase` high loads the data code (status bits [10:8]) and sets flag bit 28. The other code is not loaded by the error.
- R4: `frame_ok` in a cycle with no error pulse loads 0 into both codes. If an error pulse arrives in the same cycle, `frame_ok` is ignored.
- R5: A read of the status register (address 0) returns the codes held before that cycle and sets each code to 7 on the next cycle. If a code is loaded by an event in the same cycle, the loaded value replaces the 7 for that code.
- R6: `rec11` while `busoff_rec` is high, with no error pulse in the cycle, loads 5 into the arbitration code, leaves the data code unloaded and sets no flag. `rec11` while `busoff_rec` is low has no effect. If `frame_ok` arrives in the same cycle, the arbitration code still takes 5.
- R7: `ecc_uncorr` sets flag bit 21 and leaves both codes unchanged.
- R8: Flags are sticky. Writing 1 to a bit of the flag register (address 1) clears that bit. A set arriving in the same cycle wins over the clear.
- R9: The enable register (address 2) stores bits 21, 27 and 28 and reads 0 elsewhere. `irq` is high exactly when some flag is set and its enable bit is 1.
- R10: Writes to the status register or to address 3 have no effect. Address 3 reads 0, and the status bits outside [2:0] and [10:8] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_ev | input | 6 | Error pulses: stuff, form, ack, bit1, bit0, CRC (bit 0 first) |
| in_data_phase | input | 1 | High while the engine is in the data phase |
| busoff_rec | input | 1 | High while bus-off recovery runs |
| rec11 | input | 1 | Pulse when 11 recessive bits have been seen |
| frame_ok | input | 1 | Pulse on successful frame reception or transmission |
| ecc_uncorr | input | 1 | Pulse on uncorrectable message-RAM ECC error |
| reg_addr | input | 2 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cycle where a status read meets an error or a recovery pulse. A design that let the read win would lose that error and show 7. A design that cleared both codes would wipe the other phase's code. It also drives simultaneous error pulses, and a wrong priority would store CRC where stuff is expected. It drives `frame_ok` together with errors and with `rec11`, and a design that let completion win would hide the failure. It drives a set and a write-1-clear on the same flag in one cycle; a design that let the clear win would drop an interrupt. Finally, it sends `rec11` outside recovery, and a design that did not check `busoff_rec` would show a false bit0 code.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int N_ERR       = 6;
  localparam int CODE_W      = 3;
  localparam int REG_DW      = 32;
  localparam int ARB_LSB     = 0;
  localparam int DATA_LSB    = 8;
  localparam int ECC_BIT     = 21;
  localparam int ARB_BIT     = 27;
  localparam int DATA_BIT    = 28;

  typedef enum logic [CODE_W-1:0] {
    EC_NONE  = 3'd0,
    EC_STUFF = 3'd1,
    EC_FORM  = 3'd2,
    EC_ACK   = 3'd3,
    EC_BIT1  = 3'd4,
    EC_BIT0  = 3'd5,
    EC_CRC   = 3'd6,
    EC_IDLE  = 3'd7
  } err_code_e;

  // Lowest-numbered active pulse gives the code; scan from top so it lands last.
  function automatic logic [CODE_W-1:0] pick_code(input logic [N_ERR-1:0] ev);
    logic [CODE_W-1:0] c;
    c = EC_NONE;
    for (int i = N_ERR - 1; i >= 0; i--) begin
      if (ev[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction

  function automatic logic [REG_DW-1:0] irq_mask();
    logic [REG_DW-1:0] m;
    m = '0;
    m[ECC_BIT]  = 1'b1;
    m[ARB_BIT]  = 1'b1;
    m[DATA_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/can_err_code_sel.sv
module can_err_code_sel
  import can_err_pkg::*;
(
  input  logic [N_ERR-1:0]  err_ev,
  input  logic              in_data_phase,
  input  logic              busoff_rec,
  input  logic              rec11,
  input  logic              frame_ok,
  output logic              arb_err,
  output logic              data_err,
  output logic              rec_hit,
  output logic              arb_load,
  output logic [CODE_W-1:0] arb_code,
  output logic              data_load,
  output logic [CODE_W-1:0] data_code
);
  logic              any_err;
  logic [CODE_W-1:0] err_code;
  logic              ok_hit;

  always_comb begin
    any_err  = |err_ev;
    err_code = pick_code(err_ev);
    arb_err  = any_err & ~in_data_phase;
    data_err = any_err &  in_data_phase;
    rec_hit  = busoff_rec & rec11 & ~any_err;
    ok_hit   = frame_ok & ~any_err;

    arb_load = arb_err | rec_hit | ok_hit;
    if (arb_err)      arb_code = err_code;
    else if (rec_hit) arb_code = EC_BIT0;
    else              arb_code = EC_NONE;

    data_load = data_err | ok_hit;
    data_code = data_err ? err_code : EC_NONE;
  end
endmodule

// File: rtl/can_err_field.sv
module can_err_field
  import can_err_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rd_clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] IDLE_VAL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= IDLE_VAL;
    else if (load)   q <= load_val;
    else if (rd_clr) q <= IDLE_VAL;
  end
endmodule

// File: rtl/can_err_irq.sv
module can_err_irq
  import can_err_pkg::*;
#(
  parameter int DW = REG_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          clr_wr,
  input  logic          en_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] flags,
  output logic [DW-1:0] enable,
  output logic          irq
);
  localparam logic [DW-1:0] MASK = DW'(irq_mask());

  logic [DW-1:0] clr_vec;

  always_comb clr_vec = clr_wr ? (wdata & MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      enable <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | (set_vec & MASK);
      if (en_wr) enable <= wdata & MASK;
    end
  end

  always_comb irq = |(flags & enable);
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DW     = REG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ERR-1:0]  err_ev,
  input  logic              in_data_phase,
  input  logic              busoff_rec,
  input  logic              rec11,
  input  logic              frame_ok,
  input  logic              ecc_uncorr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int N_FLD = 2;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(2);

  // named internal events
  logic              arb_err, data_err, rec_hit;
  logic              arb_load, data_load;
  logic [CODE_W-1:0] arb_code, data_code;
  logic              status_rd, flag_wr, en_wr;
  logic [DW-1:0]     set_vec, flags, enable;
  logic [CODE_W-1:0] lec_q, dlec_q;

  logic [N_FLD-1:0]             fld_load;
  logic [N_FLD-1:0][CODE_W-1:0] fld_val, fld_q;

  can_err_code_sel u_sel (
    .err_ev       (err_ev),
    .in_data_phase(in_data_phase),
    .busoff_rec   (busoff_rec),
    .rec11        (rec11),
    .frame_ok     (frame_ok),
    .arb_err      (arb_err),
    .data_err     (data_err),
    .rec_hit      (rec_hit),
    .arb_load     (arb_load),
    .arb_code     (arb_code),
    .data_load    (data_load),
    .data_code    (data_code)
  );

  always_comb begin
    status_rd   = reg_rd & (reg_addr == A_STATUS);
    flag_wr     = reg_wr & (reg_addr == A_FLAGS);
    en_wr       = reg_wr & (reg_addr == A_ENABLE);
    fld_load[0] = arb_load;
    fld_val[0]  = arb_code;
    fld_load[1] = data_load;
    fld_val[1]  = data_code;
  end

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    can_err_field #(.W(CODE_W)) u_fld (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fld_load[g]),
      .load_val(fld_val[g]),
      .rd_clr  (status_rd),
      .q       (fld_q[g])
    );
  end

  always_comb begin
    lec_q  = fld_q[0];
    dlec_q = fld_q[1];
    set_vec           = '0;
    set_vec[ARB_BIT]  = arb_err;
    set_vec[DATA_BIT] = data_err;
    set_vec[ECC_BIT]  = ecc_uncorr;
  end

  can_err_irq #(.DW(DW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_wr (flag_wr),
    .en_wr  (en_wr),
    .wdata  (reg_wdata),
    .flags  (flags),
    .enable (enable),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: begin
        reg_rdata[ARB_LSB  +: CODE_W] = lec_q;
        reg_rdata[DATA_LSB +: CODE_W] = dlec_q;
      end
      A_FLAGS:  reg_rdata = flags;
      A_ENABLE: reg_rdata = enable;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_err_status_chk.sv
module can_err_status_chk
  import can_err_pkg::*;
#(
  parameter int DW = REG_DW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arb_err,
  input logic              data_err,
  input logic              rec_hit,
  input logic              arb_load,
  input logic              data_load,
  input logic [CODE_W-1:0] arb_code,
  input logic              status_rd,
  input logic              flag_wr,
  input logic              ecc_uncorr,
  input logic [DW-1:0]     reg_wdata,
  input logic [CODE_W-1:0] lec_q,
  input logic [CODE_W-1:0] dlec_q,
  input logic [DW-1:0]     flags,
  input logic [DW-1:0]     enable,
  input logic              irq
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (lec_q == EC_IDLE && dlec_q == EC_IDLE && flags == '0 && !irq));

  a_r3_arb_err_load: assert property (@(posedge clk) disable iff (!rst_n)
    arb_err |=> (lec_q == $past(arb_code) && flags[ARB_BIT]));

  a_r3_data_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |=> flags[DATA_BIT]);

  a_r5_read_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !arb_load && !data_load) |=> (lec_q == EC_IDLE && dlec_q == EC_IDLE));

  a_r6_recovery_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    rec_hit |=> lec_q == EC_BIT0);

  a_r6_recovery_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_hit && !flags[ARB_BIT]) |=> !flags[ARB_BIT]);

  a_r7_ecc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_uncorr |=> flags[ECC_BIT]);

  a_r7_ecc_codes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_uncorr && !arb_load && !data_load && !status_rd) |=>
      ($stable(lec_q) && $stable(dlec_q)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[ARB_BIT] && !(flag_wr && reg_wdata[ARB_BIT])) |=> flags[ARB_BIT]);

  a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
endmodule

bind can_err_status can_err_status_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arb_err   (arb_err),
  .data_err  (data_err),
  .rec_hit   (rec_hit),
  .arb_load  (arb_load),
  .data_load (data_load),
  .arb_code  (arb_code),
  .status_rd (status_rd),
  .flag_wr   (flag_wr),
  .ecc_uncorr(ecc_uncorr),
  .reg_wdata (reg_wdata),
  .lec_q     (lec_q),
  .dlec_q    (dlec_q),
  .flags     (flags),
  .enable    (enable),
  .irq       (irq)
);

// File: tb/tb_can_err_status.sv
module tb_can_err_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  err_ev = '0;
  logic        in_data_phase = 1'b0, busoff_rec = 1'b0, rec11 = 1'b0;
  logic        frame_ok = 1'b0, ecc_uncorr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  logic [2:0]  m_lec, m_dlec;
  logic [31:0] m_flags, m_en;
  localparam logic [31:0] M_MASK = 32'h1820_0000;

  always #4 clk = ~clk;

  can_err_status dut (
    .clk(clk), .rst_n(rst_n), .err_ev(err_ev), .in_data_phase(in_data_phase),
    .busoff_rec(busoff_rec), .rec11(rec11), .frame_ok(frame_ok),
    .ecc_uncorr(ecc_uncorr), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // R2: first set pulse from bit 0 upward gives code index+1
  function automatic logic [2:0] tb_code(input logic [5:0] ev);
    int k;
    k = 0;
    while (k < 6 && !ev[k]) k++;
    return (k == 6) ? 3'd0 : 3'(k + 1);
  endfunction

  function automatic logic [31:0] tb_read(input logic [1:0] a);
    case (a)
      2'd0:    return {21'd0, m_dlec, 5'd0, m_lec};
      2'd1:    return m_flags;
      2'd2:    return m_en;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic err_any, rec_ok, ok_ok, rd_s;
    logic [2:0] c;
    err_any = (err_ev != 0);
    c       = tb_code(err_ev);
    rec_ok  = busoff_rec && rec11 && !err_any;
    ok_ok   = frame_ok && !err_any;
    rd_s    = reg_rd && reg_addr == 2'd0;
    // arbitration code (R3, R4, R5, R6)
    if (err_any && !in_data_phase) m_lec = c;
    else if (rec_ok)               m_lec = 3'd5;
    else if (ok_ok)                m_lec = 3'd0;
    else if (rd_s)                 m_lec = 3'd7;
    // data code
    if (err_any && in_data_phase)  m_dlec = c;
    else if (ok_ok)                m_dlec = 3'd0;
    else if (rd_s)                 m_dlec = 3'd7;
    // flags (R7, R8) and enable (R9)
    if (reg_wr && reg_addr == 2'd1) m_flags = m_flags & ~(reg_wdata & M_MASK);
    if (err_any && !in_data_phase) m_flags[27] = 1'b1;
    if (err_any && in_data_phase)  m_flags[28] = 1'b1;
    if (ecc_uncorr)                m_flags[21] = 1'b1;
    if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata & M_MASK;
  endtask

  task automatic cyc(input string req, input logic [5:0] ev, input logic dp,
                     input logic bo, input logic r11, input logic fok, input logic ecc,
                     input logic rd, input logic wr, input logic [1:0] a, input logic [31:0] wd);
    @(negedge clk);
    err_ev = ev; in_data_phase = dp; busoff_rec = bo; rec11 = r11;
    frame_ok = fok; ecc_uncorr = ecc; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd;
    #1;
    check(req, reg_rdata, tb_read(a));
    check("R9", {31'd0, irq}, {31'd0, |(m_flags & m_en)});
    model_step();
  endtask

  task automatic rd_reg(input string req, input logic [1:0] a);
    cyc(req, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, a, 32'd0);
  endtask

  task automatic wr_reg(input string req, input logic [1:0] a, input logic [31:0] wd);
    cyc(req, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, wd);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_lec = 3'd7; m_dlec = 3'd7; m_flags = '0; m_en = '0;
    void'($urandom(32'hC0DE_0451));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd_reg("R1", 2'd1);
    rd_reg("R1", 2'd2);
    rd_reg("R1", 2'd0);
    check("R1", {21'd0, m_dlec, 5'd0, m_lec}, 32'h0000_0707);
    // R3 arbitration stuff error, R2 code
    cyc("R3", 6'b000001, 0, 0, 0, 0, 0, 0, 0, 2'd3, 0);
    rd_reg("R3", 2'd0);
    rd_reg("R3", 2'd1);
    // R2 several errors in data phase: form + CRC -> form
    cyc("R2", 6'b100010, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0);
    rd_reg("R2", 2'd0);
    // R5 read meets ack error in the same cycle
    cyc("R2", 6'b000100, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0);
    cyc("R5", 6'b000100, 0, 0, 0, 0, 0, 1, 0, 2'd0, 0);
    rd_reg("R5", 2'd0);
    // R4 frame completion, then completion with error
    cyc("R4", 6'd0, 0, 0, 0, 1, 0, 0, 0, 2'd0, 0);
    rd_reg("R4", 2'd0);
    cyc("R4", 6'b010000, 1, 0, 0, 1, 0, 0, 0, 2'd0, 0);
    rd_reg("R4", 2'd0);
    // R6 recovery: clear flags, rec11 outside recovery, then inside, then with frame_ok
    wr_reg("R8", 2'd1, 32'hFFFF_FFFF);
    cyc("R6", 6'd0, 0, 0, 1, 0, 0, 0, 0, 2'd0, 0);
    rd_reg("R6", 2'd0);
    cyc("R6", 6'd0, 0, 1, 1, 0, 0, 0, 0, 2'd0, 0);
    rd_reg("R6", 2'd1);
    rd_reg("R6", 2'd0);
    cyc("R6", 6'd0, 0, 1, 1, 1, 0, 1, 0, 2'd0, 0);
    rd_reg("R6", 2'd0);
    // R7 ECC
    cyc("R7", 6'd0, 0, 0, 0, 0, 1, 0, 0, 2'd1, 0);
    rd_reg("R7", 2'd1);
    rd_reg("R7", 2'd0);
    // R8 set wins over clear in one cycle
    cyc("R8", 6'b001000, 0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0800_0000);
    rd_reg("R8", 2'd1);
    wr_reg("R8", 2'd1, 32'h0800_0000);
    rd_reg("R8", 2'd1);
    // R9 enable register and irq
    wr_reg("R9", 2'd2, 32'hFFFF_FFFF);
    rd_reg("R9", 2'd2);
    wr_reg("R9", 2'd2, 32'h0020_0000);
    rd_reg("R9", 2'd1);
    // R10 ignored writes and unmapped address
    wr_reg("R10", 2'd0, 32'hFFFF_FFFF);
    rd_reg("R10", 2'd0);
    wr_reg("R10", 2'd3, 32'hFFFF_FFFF);
    rd_reg("R10", 2'd3);
    rd_reg("R10", 2'd2);

    // random mix, R2..R10
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] ev;
      for (int b = 0; b < 6; b++) ev[b] = ($urandom % 16) == 0;
      cyc("R2-random", ev, 1'($urandom % 2), ($urandom % 4) == 0, ($urandom % 8) == 0,
          ($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 4) == 0,
          ($urandom % 8) == 0, 2'($urandom % 4), $urandom);
    end
    rd_reg("R5", 2'd0);
    rd_reg("R8", 2'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule